// File: doc/BRIEF.md
# Strap-Armed Watchdog Timer

This block supervises software on a small microcontroller. A counter advances by one on every machine-cycle tick once the watchdog is running. If software does not refresh it before the limit is reached, the block raises a one-cycle internal reset request. After firing, the counter starts again from zero and the watchdog stays armed. A status flag stays set, so software can tell that the last reset came from the watchdog.

There are two ways to arm it. The first is a strap pin, which is sampled only while the external reset is held. The second is a software start strobe. Once armed, only the external reset can stop it. When the strap arms it, the block also raises a lockout. The power-saving mode controllers use the lockout to refuse idle, power-down and slow-down requests until the next external reset.

The defaults give a 16-bit counter and a limit of 65532 ticks. That is roughly 65 ms when a 12 MHz oscillator runs 12 clocks per machine cycle.

Top module: `strap_watchdog`

## Requirements
- R1: While running, the interval before a reset request is measured in cycles with `mc_tick` high. Clock cycles with `mc_tick` low do not advance it.
- R2: While the external reset is active, and after it is released with the strap low, `running`, `psave_lock` and `rst_req` are 0. No number of ticks causes a request until the watchdog is started.
- R3: If `strap_pin` is high on the last clock edge with `ext_rst` high, `psave_lock` is 1 after that edge. `running` becomes 1 on the first edge after `ext_rst` falls, and counting starts from zero.
- R4: A rising edge or a high level on `strap_pin` while `ext_rst` is low neither starts the watchdog nor sets `psave_lock`.
- R5: `psave_lock` keeps its value until the next external reset. Software strobes cannot change it. A reset with the strap low clears it.
- R6: A `sw_start` pulse while the watchdog is stopped and out of reset sets `running` on that edge. `psave_lock` stays 0, and counting starts from zero.
- R7: Once running, the watchdog stays running until `ext_rst`. A further `sw_start` has no effect on `running` or on when the next request fires.
- R8: `rst_req` is a single-cycle pulse. It is high after the edge that takes the TIMEOUT-th tick since start, refresh or the previous request. The counter then restarts from zero and `running` stays 1.
- R9: `sw_refresh` while running restarts the interval from zero. It wins over a tick in the same cycle, so that tick is not counted. While stopped, `sw_refresh` has no effect.
- R10: `sw_start` asserted while `ext_rst` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| ext_rst | input | 1 | External reset, active high, sampled synchronously |
| mc_tick | input | 1 | Machine-cycle enable; one count per cycle it is high |
| strap_pin | input | 1 | Strap level, sampled only during external reset |
| sw_start | input | 1 | One-cycle software start strobe |
| sw_refresh | input | 1 | One-cycle software refresh strobe |
| rst_req | output | 1 | One-cycle internal reset request |
| running | output | 1 | Watchdog armed status flag |
| psave_lock | output | 1 | Blocks the power-saving modes after a strap start |

## Verification
The bench runs a small configuration. It sweeps several tick densities and every refresh offset within the interval, so an off-by-one limit, or counting clocks instead of ticks, shows up as a request one tick early or late. It also pairs a refresh with a tick in the same cycle; a design that let the tick win would fire one tick early.

A strap raised after reset release, and a start strobe held during reset, are both checked at the status and lockout outputs. A design that sampled the strap at all times would arm or lock the watchdog there. Repeated start strobes while running are checked against the request timing; a design that treated them as a refresh would fire late.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    CA_HOLD,
    CA_CLEAR,
    CA_STEP,
    CA_WRAP
  } cnt_act_e;

  // True when the count sits one tick short of the limit.
  function automatic logic at_last_tick(input int unsigned cnt, input int unsigned limit);
    return cnt == (limit - 1);
  endfunction

  // Counter action for one clock; refresh outranks a tick.
  function automatic cnt_act_e pick_action(input logic run, input logic refresh,
                                           input logic tick, input logic last);
    if (!run || refresh) return CA_CLEAR;
    if (!tick)           return CA_HOLD;
    if (last)            return CA_WRAP;
    return CA_STEP;
  endfunction

endpackage

// File: rtl/wdt_start_ctl.sv
module wdt_start_ctl (
  input  logic clk,
  input  logic ext_rst,
  input  logic strap_pin,
  input  logic sw_start,
  output logic run_o,
  output logic lock_o
);
  logic run_q;
  logic lock_q;
  logic start_evt;

  // The strap level latched in reset acts as a standing start request.
  assign start_evt = !ext_rst && !run_q && (lock_q || sw_start);

  always_ff @(posedge clk) begin
    if (ext_rst) begin
      run_q  <= 1'b0;
      lock_q <= strap_pin;
    end else if (start_evt) begin
      run_q  <= 1'b1;
    end
  end

  assign run_o  = run_q;
  assign lock_o = lock_q;

  AST_NO_STOP: assert property (@(posedge clk) disable iff (ext_rst) run_q |=> run_q) else $error("watchdog stopped"); // R7
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (ext_rst) lock_q |=> lock_q) else $error("lockout dropped"); // R5
  AST_NO_LATE_LOCK: assert property (@(posedge clk) disable iff (ext_rst) !lock_q |=> !lock_q) else $error("lockout set outside reset"); // R4
  AST_STRAP_RUNS: assert property (@(posedge clk) disable iff (ext_rst) lock_q |=> run_q) else $error("strap did not start"); // R3

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned TIMEOUT = 65532
) (
  input  logic clk,
  input  logic ext_rst,
  input  logic run,
  input  logic tick,
  input  logic refresh,
  output logic fire_o
);
  localparam int unsigned LAST = TIMEOUT - 1;

  logic [CNT_W-1:0] cnt_q;
  logic             fire_q;
  logic             last;
  logic             wrap_evt;
  cnt_act_e         act;

  assign last     = at_last_tick(32'(cnt_q), TIMEOUT);
  assign act      = pick_action(run, refresh, tick, last);
  assign wrap_evt = (act == CA_WRAP);

  always_ff @(posedge clk) begin
    if (ext_rst) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= wrap_evt;
      unique case (act)
        CA_CLEAR, CA_WRAP: cnt_q <= '0;
        CA_STEP:           cnt_q <= cnt_q + 1'b1;
        default:           cnt_q <= cnt_q;
      endcase
    end
  end

  assign fire_o = fire_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (ext_rst) 32'(cnt_q) <= LAST) else $error("count beyond limit"); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (ext_rst) !run |-> cnt_q == '0) else $error("count moved while stopped"); // R2
  AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (ext_rst) fire_q |=> !fire_q) else $error("request wider than one cycle"); // R8
  AST_FIRE_RUNNING: assert property (@(posedge clk) disable iff (ext_rst) fire_q |-> run) else $error("request while stopped"); // R8
  AST_REFRESH_CLEARS: assert property (@(posedge clk) disable iff (ext_rst) (run && refresh) |=> (cnt_q == '0 && !fire_q)) else $error("refresh ignored"); // R9

endmodule

// File: rtl/strap_watchdog.sv
module strap_watchdog #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned TIMEOUT = 65532
) (
  input  logic clk,
  input  logic ext_rst,
  input  logic mc_tick,
  input  logic strap_pin,
  input  logic sw_start,
  input  logic sw_refresh,
  output logic rst_req,
  output logic running,
  output logic psave_lock
);
  logic run_w;
  logic lock_w;
  logic fire_w;

  wdt_start_ctl u_start (
    .clk       (clk),
    .ext_rst   (ext_rst),
    .strap_pin (strap_pin),
    .sw_start  (sw_start),
    .run_o     (run_w),
    .lock_o    (lock_w)
  );

  wdt_counter #(
    .CNT_W   (CNT_W),
    .TIMEOUT (TIMEOUT)
  ) u_cnt (
    .clk     (clk),
    .ext_rst (ext_rst),
    .run     (run_w),
    .tick    (mc_tick),
    .refresh (sw_refresh),
    .fire_o  (fire_w)
  );

  assign rst_req    = fire_w;
  assign running    = run_w;
  assign psave_lock = lock_w;

  AST_LOCK_IMPLIES_RUN: assert property (@(posedge clk) disable iff (ext_rst) (psave_lock && $past(psave_lock) && !$past(ext_rst)) |-> running) else $error("locked but idle"); // R3

endmodule

// File: tb/sim_strap_watchdog.sv
module sim_strap_watchdog;
  localparam int unsigned W = 5;
  localparam int unsigned T = 13;

  logic clk = 1'b0;
  logic ext_rst = 1'b1, mc_tick = 1'b0, strap_pin = 1'b0, sw_start = 1'b0, sw_refresh = 1'b0;
  logic rst_req, running, psave_lock;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // reference state
  bit m_run = 1'b0, m_lock = 1'b0, m_fire = 1'b0;
  int m_el = 0;

  always #4 clk = ~clk;

  strap_watchdog #(.CNT_W(W), .TIMEOUT(T)) u0 (
    .clk(clk), .ext_rst(ext_rst), .mc_tick(mc_tick), .strap_pin(strap_pin),
    .sw_start(sw_start), .sw_refresh(sw_refresh),
    .rst_req(rst_req), .running(running), .psave_lock(psave_lock)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  // One clock: drive, predict, take the edge, compare away from it.
  task automatic step(input string tag, input bit rst, input bit strap, input bit tk,
                      input bit st, input bit rf);
    bit nr, nl, nf;
    int ne;
    ext_rst = rst; strap_pin = strap; mc_tick = tk; sw_start = st; sw_refresh = rf;
    if (rst) begin
      nr = 0; nl = strap; nf = 0; ne = 0;
    end else begin
      nl = m_lock;
      nr = m_run | m_lock | st;
      nf = m_run && !rf && tk && (m_el + 1 == T);
      if (!m_run || rf) ne = 0;
      else if (tk)      ne = (m_el + 1) % T;
      else              ne = m_el;
    end
    @(posedge clk);
    #2;
    m_run = nr; m_lock = nl; m_fire = nf; m_el = ne;
    chk(tag, "rst_req", int'(rst_req), int'(m_fire));
    chk(tag, "running", int'(running), int'(m_run));
    chk(tag, "psave_lock", int'(psave_lock), int'(m_lock));
    sw_start = 0; sw_refresh = 0;
  endtask

  function automatic bit pat_tick(input int p, input int i);
    case (p)
      0: return 1'b1;
      1: return (i % 2) == 0;
      2: return (i % 3) == 1;
      default: return ((i * 7 + 3) % 5) < 2;
    endcase
  endfunction

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #2;
    // R2: reset with strap low, then many ticks while stopped
    for (int i = 0; i < 3; i++) step("R2", 1, 0, 1, 0, 0);
    for (int i = 0; i < 3 * T; i++) step("R2", 0, 0, 1, 0, 0);
    // R9: refresh while stopped does nothing
    for (int i = 0; i < T; i++) step("R9", 0, 0, 1, 0, 1);
    // R4: strap rising out of reset
    for (int i = 0; i < 2 * T; i++) step("R4", 0, 1, 1, 0, 0);
    chk("R4", "running after late strap", int'(running), 0);
    chk("R4", "lock after late strap", int'(psave_lock), 0);
    // R10: start strobe during reset ignored
    for (int i = 0; i < 3; i++) step("R10", 1, 0, 1, 1, 0);
    step("R10", 0, 0, 1, 0, 0);
    chk("R10", "running after start in reset", int'(running), 0);
    // R6: software start
    step("R6", 0, 0, 0, 1, 0);
    chk("R6", "running after start", int'(running), 1);
    chk("R6", "lock after sw start", int'(psave_lock), 0);
    // R6/R8: first request exactly T ticks after start
    for (int i = 0; i < T - 1; i++) step("R6", 0, 0, 1, 0, 0);
    chk("R8", "no early request", int'(rst_req), 0);
    step("R8", 0, 0, 1, 0, 0);
    chk("R8", "request at limit", int'(rst_req), 1);
    step("R8", 0, 0, 0, 0, 0);
    chk("R8", "request one cycle", int'(rst_req), 0);
    chk("R8", "still running", int'(running), 1);
    // R1: tick density sweep
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < 4 * T + 7; i++) step("R1", 0, 0, pat_tick(p, i), 0, 0);
    // R7: repeated start strobes while running
    for (int i = 0; i < 3 * T; i++) step("R7", 0, 0, 1, (i % 4) == 0, 0);
    // R9: refresh at every offset, with a tick in the same cycle
    for (int off = 0; off <= T; off++) begin
      for (int i = 0; i < off; i++) step("R9", 0, 0, 1, 0, 0);
      step("R9", 0, 0, 1, 0, 1);
    end
    for (int i = 0; i < T + 2; i++) step("R9", 0, 0, 1, 0, 0);
    // R3: strap high in reset, released low afterwards
    for (int i = 0; i < 3; i++) step("R3", 1, 1, 1, 0, 0);
    chk("R3", "lock during reset", int'(psave_lock), 1);
    chk("R3", "idle during reset", int'(running), 0);
    step("R3", 0, 0, 0, 0, 0);
    chk("R3", "running after release", int'(running), 1);
    for (int i = 0; i < 3 * T; i++) step("R3", 0, 0, pat_tick(3, i), 0, 0);
    // R5: software strobes cannot touch the lockout
    for (int i = 0; i < 2 * T; i++) step("R5", 0, 0, 1, i[0], !i[0]);
    chk("R5", "lock held", int'(psave_lock), 1);
    for (int i = 0; i < 2; i++) step("R5", 1, 0, 0, 0, 0);
    chk("R5", "lock cleared by reset", int'(psave_lock), 0);
    step("R5", 0, 0, 0, 0, 0);
    chk("R2", "idle after reset", int'(running), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule